// File: doc/BRIEF.md
# Asynchronous Memory Access Sequencer

This block turns a 32-bit internal read or write request into a series of timed cycles on an external asynchronous memory bus. Each external cycle has three phases. A setup phase asserts chip select and the address. A strobe phase drives the output enable for a read or the write enable for a write. A hold phase keeps chip select and the address stable after the strobe. A width setting chooses an external data path of 8 or 16 bits. At 8 bits one request becomes four external accesses, and at 16 bits it becomes two. The least significant part always goes first, and the external address rises by one for each access.

The strobe can be stretched by a wait input from the memory. The wait input passes through a two-flop synchronizer. It only takes effect when an enable bit is set, and a polarity bit chooses which pin level means "wait". The stretch is bounded by `(cfg_max_wait + 1) * 16` cycles, counted from the start of each strobe. If the wait is still present when that bound is reached, the access goes on anyway: the data bus is captured and a one-cycle timeout pulse is raised for the interrupt logic. The requester holds `req_valid` until it sees the single-cycle `req_ack`. The ack arrives only after the hold phase of the last external access.

Top module: `async_mem_seq`

## Requirements
- R1: After reset, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, and `req_ack`, `timeout_pulse` and `mem_dout_en` are 0.
- R2: With `cfg_wide`=0 a request makes exactly four external accesses at addresses `req_addr`, `req_addr`+1, `req_addr`+2, `req_addr`+3. Read byte k is taken from `mem_din[7:0]` of access k and lands in `rd_data[8k+7:8k]`.
- R3: With `cfg_wide`=1 a request makes exactly two external accesses at addresses `req_addr` and `req_addr`+1. Access k supplies `rd_data[16k+15:16k]` from `mem_din[15:0]`.
- R4: On a write, access k drives the matching byte (at 8 bits) or halfword (at 16 bits) of `req_wdata` on the low bits of `mem_dout`. `mem_we_n` is low only during the strobe phase, and `mem_dout_en` is high whenever `mem_we_n` is low.
- R5: Each external access keeps `mem_cs_n` low for SETUP_CYC + strobe length + HOLD_CYC cycles. `mem_oe_n` (reads) or `mem_we_n` (writes) is low for exactly the strobe length, and the two are never low together.
- R6: With `cfg_wait_en`=0 every strobe lasts exactly STROBE_CYC cycles, whatever the level of `mem_wait`.
- R7: The wait is asserted when `mem_wait` equals `cfg_wait_pol`: with polarity 1 the strobe waits while the pin is high, and with polarity 0 it waits while the pin is low.
- R8: If the wait stays asserted, the strobe lasts `(cfg_max_wait+1)*16` cycles. One `timeout_pulse` follows in the first hold cycle, and the access still completes with the bus data captured.
- R9: If the pin deasserts at the negative edge of strobe cycle R (counted from 0), the strobe lasts max(STROBE_CYC, R+3) cycles, capped at the limit. No timeout is raised unless the synchronized wait is still asserted in the last cycle allowed.
- R10: `req_ack` is high for one cycle, directly after the last hold cycle, with `mem_cs_n` high. `rd_data` holds the assembled word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held until ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | First external address |
| req_wdata | input | 32 | Write word |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Assembled read word |
| cfg_wide | input | 1 | 0 = 8-bit bus, 1 = 16-bit bus |
| cfg_wait_en | input | 1 | Enables wait stretching |
| cfg_wait_pol | input | 1 | Pin level that means wait |
| cfg_max_wait | input | 8 | Timeout limit is (value+1)*16 cycles |
| mem_wait | input | 1 | Asynchronous wait pin |
| mem_din | input | 16 | Data from memory |
| mem_addr | output | ADDR_W | External address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dout | output | 16 | Data to memory |
| mem_dout_en | output | 1 | Drive enable for mem_dout |
| timeout_pulse | output | 1 | One-cycle wait timeout event |

## Verification
The wait pin's release and the end of the timeout window can fall in the same strobe cycle. The bench provokes this directly by releasing the pin at strobe cycle limit−3, so that the synchronized release reaches the last allowed cycle. It also releases one cycle later, at limit−2, which misses that cycle. Both cases must give a strobe of exactly the limit length. The first must raise no timeout and the second exactly one. Random release points near the limit are judged by the same rule, computed from the synchronizer delay of two cycles.

// File: rtl/async_mem_seq.sv
module async_mem_seq #(
  parameter int ADDR_W     = 16,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_ack,
  output logic [31:0]       rd_data,
  input  logic              cfg_wide,
  input  logic              cfg_wait_en,
  input  logic              cfg_wait_pol,
  input  logic [7:0]        cfg_max_wait,
  input  logic              mem_wait,
  input  logic [15:0]       mem_din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [15:0]       mem_dout,
  output logic              mem_dout_en,
  output logic              timeout_pulse
);

  localparam int CW = 13;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD} phase_t;

  phase_t            phase;
  logic [CW-1:0]     cnt;
  logic [1:0]        sub;
  logic              wide_q, wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [31:0]       wdata_q;
  logic [1:0]        wsync;

  logic [CW-1:0] lim;
  logic          wait_act, setup_end, strobe_end, hold_end, last_sub;

  assign lim        = ({5'd0, cfg_max_wait} + CW'(1)) << 4;
  assign wait_act   = cfg_wait_en && (wsync[1] == cfg_wait_pol);
  assign setup_end  = (phase == S_SETUP) && (cnt == CW'(SETUP_CYC - 1));
  assign strobe_end = (phase == S_STROBE) && (cnt >= CW'(STROBE_CYC - 1)) &&
                      (!wait_act || cnt == lim - CW'(1));
  assign hold_end   = (phase == S_HOLD) && (cnt == CW'(HOLD_CYC - 1));
  assign last_sub   = wide_q ? (sub == 2'd1) : (sub == 2'd3);

  assign mem_addr    = base_q + ADDR_W'(sub);
  assign mem_cs_n    = (phase == S_IDLE);
  assign mem_oe_n    = !((phase == S_STROBE) && !wr_q);
  assign mem_we_n    = !((phase == S_STROBE) && wr_q);
  assign mem_dout_en = (phase != S_IDLE) && wr_q;
  assign mem_dout    = wide_q ? wdata_q[16*sub[0] +: 16] : {8'h00, wdata_q[8*sub +: 8]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wsync <= 2'b00;
    else        wsync <= {wsync[0], mem_wait};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase         <= S_IDLE;
      cnt           <= '0;
      sub           <= '0;
      wide_q        <= 1'b0;
      wr_q          <= 1'b0;
      base_q        <= '0;
      wdata_q       <= '0;
      rd_data       <= '0;
      req_ack       <= 1'b0;
      timeout_pulse <= 1'b0;
    end else begin
      req_ack       <= 1'b0;
      timeout_pulse <= 1'b0;
      cnt           <= cnt + CW'(1);
      case (phase)
        S_IDLE: begin
          cnt <= '0;
          if (req_valid && !req_ack) begin
            phase   <= S_SETUP;
            sub     <= '0;
            wide_q  <= cfg_wide;
            wr_q    <= req_write;
            base_q  <= req_addr;
            wdata_q <= req_wdata;
          end
        end
        S_SETUP:
          if (setup_end) begin
            phase <= S_STROBE;
            cnt   <= '0;
          end
        S_STROBE:
          if (strobe_end) begin
            phase         <= S_HOLD;
            cnt           <= '0;
            timeout_pulse <= wait_act;
            if (!wr_q) begin
              if (wide_q) rd_data[16*sub[0] +: 16] <= mem_din;
              else        rd_data[8*sub +: 8]      <= mem_din[7:0];
            end
          end
        default:
          if (hold_end) begin
            cnt <= '0;
            if (last_sub) begin
              phase   <= S_IDLE;
              req_ack <= 1'b1;
            end else begin
              phase <= S_SETUP;
              sub   <= sub + 2'd1;
            end
          end
      endcase
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R5
  AST_WE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dout_en); // R4
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> mem_cs_n); // R10
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack); // R10
  AST_TIMEOUT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> $past(!mem_oe_n || !mem_we_n) && mem_oe_n && mem_we_n); // R8
  AST_STROBE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_STROBE) |-> (cnt < lim)); // R8
  AST_NO_WAIT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_STROBE && !cfg_wait_en) |-> (cnt < CW'(STROBE_CYC))); // R6

endmodule

// File: tb/tb_async_mem_seq.sv
module tb_async_mem_seq;
  localparam int AW = 16, SC = 2, STC = 3, HC = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rd_data;
  logic req_ack;
  logic cfg_wide = 0, cfg_wait_en = 0, cfg_wait_pol = 0;
  logic [7:0] cfg_max_wait = '0;
  logic mem_wait = 0;
  logic [15:0] mem_din, mem_dout;
  logic [AW-1:0] mem_addr;
  logic mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en, timeout_pulse;

  logic [15:0] mem [0:255];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  async_mem_seq #(.ADDR_W(AW), .SETUP_CYC(SC), .STROBE_CYC(STC), .HOLD_CYC(HC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack), .rd_data(rd_data),
    .cfg_wide(cfg_wide), .cfg_wait_en(cfg_wait_en), .cfg_wait_pol(cfg_wait_pol),
    .cfg_max_wait(cfg_max_wait), .mem_wait(mem_wait), .mem_din(mem_din),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .timeout_pulse(timeout_pulse));

  assign mem_din = mem[mem_addr[7:0]];

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h3b1 + 16'h5a);
    end else if (!mem_we_n) begin
      if (cfg_wide) mem[mem_addr[7:0]] = mem_dout;
      else          mem[mem_addr[7:0]] = {8'h00, mem_dout[7:0]};
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(input bit en, input int mode, input int lim, input int r);
    if (!en || mode == 0) return STC;
    if (mode == 1) return lim;
    if (r + 3 > lim) return lim;
    return (r + 3 > STC) ? r + 3 : STC;
  endfunction

  function automatic int exp_to(input bit en, input int mode, input int lim, input int r);
    if (!en || mode == 0) return 0;
    if (mode == 1) return 1;
    return (r + 3 > lim) ? 1 : 0;
  endfunction

  function automatic logic [31:0] model_read(input bit wide, input int a);
    if (wide) return {mem[a+1], mem[a]};
    return {mem[a+3][7:0], mem[a+2][7:0], mem[a+1][7:0], mem[a][7:0]};
  endfunction

  // mode 0: pin never waits, 1: pin always waits, 2: release at strobe cycle r
  task automatic run(input bit wr, input bit wide, input int a, input logic [31:0] wd,
                     input bit en, input bit pol, input logic [7:0] mw,
                     input int mode, input int r, input string tag);
    int n, lim, elen, eto, nstr, len, cs, tos, guard;
    bit in_str, done;
    logic [31:0] exp;
    n = wide ? 2 : 4;
    lim = (int'(mw) + 1) * 16;
    elen = exp_len(en, mode, lim, r);
    eto = exp_to(en, mode, lim, r);
    exp = model_read(wide, a);
    cfg_wide = wide; cfg_wait_en = en; cfg_wait_pol = pol; cfg_max_wait = mw;
    mem_wait = (mode == 0) ? !pol : pol;
    repeat (3) @(negedge clk);
    req_write = wr; req_addr = AW'(a); req_wdata = wd; req_valid = 1;
    nstr = 0; len = 0; cs = 0; tos = 0; in_str = 0; done = 0; guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (!mem_cs_n) cs++;
      if (timeout_pulse) tos++;
      if (!mem_oe_n || !mem_we_n) begin
        if (!in_str) begin
          len = 0;
          chk(int'(mem_addr) == a + nstr, wide ? "R3" : "R2", {tag, " address"}, mem_addr, a + nstr);
          chk(mem_oe_n == wr && mem_we_n == !wr, "R5", {tag, " strobe kind"}, {mem_oe_n, mem_we_n}, {wr, !wr});
          if (wr) begin
            if (wide) chk(mem_dout == wd[16*nstr +: 16], "R4", {tag, " write half"}, mem_dout, wd[16*nstr +: 16]);
            else      chk(mem_dout[7:0] == wd[8*nstr +: 8], "R4", {tag, " write byte"}, mem_dout[7:0], wd[8*nstr +: 8]);
          end
        end
        len++;
        if (mode == 2 && len == r + 1) mem_wait = !pol;
        in_str = 1;
      end else if (in_str) begin
        chk(len == elen, !en ? "R6" : (mode == 2 ? "R9" : (mode == 1 ? "R8" : "R7")),
            {tag, " strobe length"}, len, elen);
        if (mode == 2) mem_wait = pol;
        nstr++;
        in_str = 0;
      end
      if (req_ack) begin
        done = 1;
        req_valid = 0;
        chk(mem_cs_n == 1'b1, "R10", {tag, " cs high at ack"}, mem_cs_n, 1);
        if (!wr) chk(rd_data == exp, wide ? "R3" : "R2", {tag, " read data"}, rd_data, exp);
      end
    end
    chk(done, "R10", {tag, " ack seen"}, done, 1);
    chk(nstr == n, wide ? "R3" : "R2", {tag, " access count"}, nstr, n);
    chk(cs == n * (SC + elen + HC), "R5", {tag, " cs cycles"}, cs, n * (SC + elen + HC));
    chk(tos == n * eto, "R8", {tag, " timeout pulses"}, tos, n * eto);
    @(negedge clk);
    chk(req_ack == 1'b0, "R10", {tag, " ack one cycle"}, req_ack, 0);
    if (wr) begin
      if (wide) chk({mem[a+1], mem[a]} == wd, "R4", {tag, " stored word"}, {mem[a+1], mem[a]}, wd);
      else chk({mem[a+3][7:0], mem[a+2][7:0], mem[a+1][7:0], mem[a][7:0]} == wd, "R4",
               {tag, " stored bytes"}, {mem[a+3][7:0], mem[a+2][7:0], mem[a+1][7:0], mem[a][7:0]}, wd);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed, lim, md, rr;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n, "R1", "strobes in reset", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
    chk(!req_ack && !timeout_pulse && !mem_dout_en, "R1", "flags in reset", {req_ack, timeout_pulse, mem_dout_en}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(mem_cs_n && !req_ack && !timeout_pulse, "R1", "idle after reset", {mem_cs_n, req_ack, timeout_pulse}, 3'b100);

    run(0, 0, 16, 0, 0, 1, 0, 0, 0, "narrow read");
    run(0, 1, 40, 0, 0, 1, 0, 0, 0, "wide read");
    run(1, 0, 60, 32'hA1B2C3D4, 0, 1, 0, 0, 0, "narrow write");
    run(1, 1, 80, 32'h13579BDF, 0, 1, 0, 0, 0, "wide write");
    run(0, 0, 60, 0, 0, 1, 0, 1, 0, "wait ignored when disabled");
    run(0, 1, 10, 0, 1, 1, 0, 1, 0, "pol1 pin high waits");
    run(0, 1, 12, 0, 1, 0, 0, 1, 0, "pol0 pin low waits");
    run(0, 1, 14, 0, 1, 0, 0, 0, 0, "pol0 pin high runs");
    run(0, 0, 20, 0, 1, 1, 1, 1, 0, "timeout narrow");
    run(1, 1, 90, 32'hCAFEF00D, 1, 0, 0, 1, 0, "timeout write");
    run(0, 1, 30, 0, 1, 1, 0, 2, 5, "release early");
    run(0, 1, 32, 0, 1, 1, 0, 2, 13, "release hits limit");
    run(0, 1, 34, 0, 1, 1, 0, 2, 14, "release misses limit");
    run(0, 1, 36, 0, 1, 1, 0, 2, 0, "release before min");

    for (int i = 0; i < 40; i++) begin
      md = int'($urandom_range(0, 2));
      lim = (int'($urandom_range(0, 2)) + 1) * 16;
      rr = int'($urandom_range(0, lim - 1));
      run(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), int'($urandom_range(0, 200)),
          $urandom, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          8'(lim / 16 - 1), md, rr, "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule